// File: doc/BRIEF.md
# Nine-Switch Converter Leg Gate Generator

This block turns per-leg modulating references into gate commands for a three-leg, nine-switch power converter. Each leg has an upper, a shared centre and a lower device. The block holds an up/down triangular carrier of its own and compares it with an upper reference and a lower reference for every leg. The centre device serves both converter outputs, so its command is never compared against the carrier. It is derived from the outer two commands, which keeps exactly two devices of each leg conducting in every cycle.

References are captured only at the two turning points of the carrier, so a gate edge cannot be disturbed by a reference that changes in the middle of a ramp. A captured pair that would leave both outer devices off is repaired: the upper reference is raised to the lower threshold and a per-leg fault flag is set. References that fall outside the carrier span are saturated to its limits. Dead time, gate drive and offset computation sit outside this block.

Top module: `nsw_gate_top`

## Requirements
- R1: In every leg exactly two of the three gate outputs are high in every cycle; the states with all three on and with both outer devices off never appear.
- R2: The centre gate of a leg is high unless both the upper and the lower gate of that leg are high.
- R3: The carrier is signed and runs from -PEAK to +PEAK and back in steps of one per clock, where PEAK = CLK_HZ/(4*FSW_HZ). The period is therefore 4*PEAK clocks and the switching rate is FSW_HZ. After reset the carrier reads -PEAK and counts upward.
- R4: The upper gate goes high in the clock after a cycle whose carrier value c is strictly less than the held upper reference. Otherwise it is low.
- R5: The lower gate goes high in the clock after a cycle whose carrier value c is greater than or equal to the negated held lower reference. Otherwise it is low.
- R6: The references are captured only in a cycle whose carrier value equals +PEAK or -PEAK. The captured values take effect from the next clock. Input changes at any other time have no effect.
- R7: If the captured upper reference is below the negated lower reference, the held upper reference becomes the negated lower reference and the leg's fault output is set. Each capture without this condition clears the fault.
- R8: Captured references above +PEAK are held as +PEAK, and those below -PEAK are held as -PEAK.
- R9: While reset is high, the carrier reads -PEAK. Every leg outputs upper=0, centre=1, lower=1, the fault outputs are 0, and the held references are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_top_i | input | LEGS x MOD_W | Signed upper reference per leg |
| mod_bot_i | input | LEGS x MOD_W | Signed lower reference per leg |
| carrier_o | output | MOD_W | Signed carrier value |
| gate_top_o | output | LEGS | Upper device commands |
| gate_mid_o | output | LEGS | Centre device commands |
| gate_bot_o | output | LEGS | Lower device commands |
| fault_o | output | LEGS | Per-leg reference-order fault |

## Verification
The legs are first run with fixed, well-ordered references that give different duty splits. This separates the upper and lower comparison thresholds, including the equality point where one compare is strict and the other is not. A second pattern changes the references every few cycles, mostly mid-ramp, so a design that samples outside the turning points gives gate edges at the wrong carrier values. Inverted and equal reference pairs separate the clamp and fault path from the legal boundary case. Out-of-range references show whether saturation is applied before the order check, and a reset taken mid-run shows that carrier and gates return to their initial state.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
  typedef struct packed {
    logic top;
    logic mid;
    logic bot;
  } leg_gates_t;

  localparam leg_gates_t LEG_SAFE = 3'b011;
endpackage

// File: rtl/nsw_carrier.sv
module nsw_carrier #(
  parameter int PEAK  = 16,
  parameter int MOD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic signed [MOD_W-1:0] car_o,
  output logic                    smp_o
);
  localparam logic signed [MOD_W-1:0] PK = MOD_W'(PEAK);
  localparam logic signed [MOD_W-1:0] NK = -PK;

  logic up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      car_o <= NK;
      up_q  <= 1'b1;
    end else if (up_q) begin
      car_o <= car_o + MOD_W'(1);
      if (car_o == PK - MOD_W'(1)) up_q <= 1'b0;
    end else begin
      car_o <= car_o - MOD_W'(1);
      if (car_o == NK + MOD_W'(1)) up_q <= 1'b1;
    end
  end

  assign smp_o = (car_o == PK) || (car_o == NK);

  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    (car_o <= PK) && (car_o >= NK));
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((car_o - $past(car_o)) == 1) || ((car_o - $past(car_o)) == -1)));
  p_turn_r3: assert property (@(posedge clk) disable iff (rst)
    smp_o |=> !smp_o);
endmodule

// File: rtl/nsw_leg_hold.sv
module nsw_leg_hold #(
  parameter int PEAK  = 16,
  parameter int MOD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_i,
  input  logic signed [MOD_W-1:0] top_in,
  input  logic signed [MOD_W-1:0] bot_in,
  output logic signed [MOD_W-1:0] top_q,
  output logic signed [MOD_W-1:0] bot_q,
  output logic                    fault_q
);
  localparam logic signed [MOD_W-1:0] PK = MOD_W'(PEAK);
  localparam logic signed [MOD_W-1:0] NK = -PK;

  function automatic logic signed [MOD_W-1:0] limit(input logic signed [MOD_W-1:0] v);
    if (v > PK) return PK;
    if (v < NK) return NK;
    return v;
  endfunction

  logic signed [MOD_W-1:0] top_s, bot_s, floor_s;
  logic                    inverted;

  always_comb begin
    top_s    = limit(top_in);
    bot_s    = limit(bot_in);
    floor_s  = -bot_s;
    inverted = top_s < floor_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q   <= '0;
      bot_q   <= '0;
      fault_q <= 1'b0;
    end else if (smp_i) begin
      bot_q   <= bot_s;
      top_q   <= inverted ? floor_s : top_s;
      fault_q <= inverted;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !smp_i |=> ($stable(top_q) && $stable(bot_q) && $stable(fault_q)));
  p_order_r7: assert property (@(posedge clk) disable iff (rst)
    top_q >= -bot_q);
  p_fault_r7: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> (top_q == -bot_q));
  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (top_q <= PK) && (top_q >= NK) && (bot_q <= PK) && (bot_q >= NK));
endmodule

// File: rtl/nsw_leg_gate.sv
module nsw_leg_gate
  import nsw_pkg::*;
#(
  parameter int MOD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [MOD_W-1:0] car_i,
  input  logic signed [MOD_W-1:0] top_ref,
  input  logic signed [MOD_W-1:0] bot_ref,
  output leg_gates_t              g_q
);
  logic on_top, on_bot;

  always_comb begin
    on_top = car_i < top_ref;
    on_bot = car_i >= -bot_ref;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q <= LEG_SAFE;
    end else begin
      g_q.top <= on_top;
      g_q.bot <= on_bot;
      g_q.mid <= !(on_top && on_bot);
    end
  end

  p_two_on_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(g_q) == 2);
  p_outer_r1: assert property (@(posedge clk) disable iff (rst)
    g_q.top || g_q.bot);
endmodule

// File: rtl/nsw_gate_top.sv
module nsw_gate_top
  import nsw_pkg::*;
#(
  parameter int LEGS   = 3,
  parameter int MOD_W  = 18,
  parameter int CLK_HZ = 250_000_000,
  parameter int FSW_HZ = 1000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LEGS-1:0][MOD_W-1:0]  mod_top_i,
  input  logic [LEGS-1:0][MOD_W-1:0]  mod_bot_i,
  output logic [MOD_W-1:0]            carrier_o,
  output logic [LEGS-1:0]             gate_top_o,
  output logic [LEGS-1:0]             gate_mid_o,
  output logic [LEGS-1:0]             gate_bot_o,
  output logic [LEGS-1:0]             fault_o
);
  localparam int PEAK = CLK_HZ / (4 * FSW_HZ);

  logic signed [MOD_W-1:0] car;
  logic                    smp;

  nsw_carrier #(.PEAK(PEAK), .MOD_W(MOD_W)) u_car (
    .clk  (clk),
    .rst  (rst),
    .car_o(car),
    .smp_o(smp)
  );

  assign carrier_o = car;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic signed [MOD_W-1:0] top_h, bot_h;
    leg_gates_t              gates;

    nsw_leg_hold #(.PEAK(PEAK), .MOD_W(MOD_W)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .smp_i  (smp),
      .top_in ($signed(mod_top_i[g])),
      .bot_in ($signed(mod_bot_i[g])),
      .top_q  (top_h),
      .bot_q  (bot_h),
      .fault_q(fault_o[g])
    );

    nsw_leg_gate #(.MOD_W(MOD_W)) u_gate (
      .clk    (clk),
      .rst    (rst),
      .car_i  (car),
      .top_ref(top_h),
      .bot_ref(bot_h),
      .g_q    (gates)
    );

    assign gate_top_o[g] = gates.top;
    assign gate_mid_o[g] = gates.mid;
    assign gate_bot_o[g] = gates.bot;
  end
endmodule

// File: tb/nsw_gate_top_test.sv
`timescale 1ns/1ps
module nsw_gate_top_test;
  localparam int LEGS   = 3;
  localparam int MOD_W  = 8;
  localparam int CLK_HZ = 64000;
  localparam int FSW_HZ = 1000;
  localparam int PK     = CLK_HZ / (4 * FSW_HZ);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LEGS-1:0][MOD_W-1:0] mt = '0;
  logic [LEGS-1:0][MOD_W-1:0] mb = '0;
  logic [MOD_W-1:0] car_o;
  logic [LEGS-1:0]  g_top, g_mid, g_bot, flt;

  nsw_gate_top #(.LEGS(LEGS), .MOD_W(MOD_W), .CLK_HZ(CLK_HZ), .FSW_HZ(FSW_HZ)) uut (
    .clk(clk), .rst(rst), .mod_top_i(mt), .mod_bot_i(mb),
    .carrier_o(car_o), .gate_top_o(g_top), .gate_mid_o(g_mid),
    .gate_bot_o(g_bot), .fault_o(flt)
  );

  always #2 clk = ~clk;

  typedef struct {
    int              car;
    logic [LEGS-1:0] t, m, b, f;
    bit              in_rst;
  } exp_t;

  exp_t  q[$];
  int    errors = 0;
  int    checks = 0;
  string phase  = "reset R9";

  int              m_car;
  bit              m_up;
  int              ht[LEGS];
  int              hb[LEGS];
  logic [LEGS-1:0] mf;

  function automatic int sat(int v);
    if (v > PK) return PK;
    if (v < -PK) return -PK;
    return v;
  endfunction

  // reference model: pushes the expected outputs of each edge
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      m_car = -PK; m_up = 1'b1; mf = '0;
      for (int i = 0; i < LEGS; i++) begin ht[i] = 0; hb[i] = 0; end
      e.t = '0; e.m = '1; e.b = '1;
      e.in_rst = 1'b1;
    end else begin
      e.in_rst = 1'b0;
      for (int i = 0; i < LEGS; i++) begin
        e.t[i] = (m_car < ht[i]);
        e.b[i] = (m_car >= -hb[i]);
        e.m[i] = !(e.t[i] && e.b[i]);
      end
      if (m_car == PK || m_car == -PK) begin
        for (int i = 0; i < LEGS; i++) begin
          int st, sb;
          st = sat(int'($signed(mt[i])));
          sb = sat(int'($signed(mb[i])));
          hb[i] = sb;
          if (st < -sb) begin ht[i] = -sb; mf[i] = 1'b1; end
          else begin ht[i] = st; mf[i] = 1'b0; end
        end
      end
      if (m_up) begin m_car++; if (m_car == PK) m_up = 1'b0; end
      else begin m_car--; if (m_car == -PK) m_up = 1'b1; end
    end
    e.car = m_car;
    e.f   = mf;
    q.push_back(e);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, phase, act, expv, $time);
    end
  endtask

  // monitor: compares each edge's result away from the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      int   c;
      e = q.pop_front();
      c = int'($signed(car_o));
      chk(c == e.car, e.in_rst ? "R9 carrier" : "R3 carrier", c, e.car);
      chk(g_top == e.t, e.in_rst ? "R9 top" : "R4 top gate", g_top, e.t);
      chk(g_bot == e.b, e.in_rst ? "R9 bottom" : "R5 bottom gate", g_bot, e.b);
      chk(g_mid == e.m, "R2 centre gate", g_mid, e.m);
      chk(flt == e.f, "R7 fault", flt, e.f);
      for (int i = 0; i < LEGS; i++)
        chk($countones({g_top[i], g_mid[i], g_bot[i]}) == 2, "R1 two on",
            $countones({g_top[i], g_mid[i], g_bot[i]}), 2);
    end
  end

  task automatic set_leg(input int i, input int t, input int b);
    mt[i] = MOD_W'(t);
    mb[i] = MOD_W'(b);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    // well-ordered references, distinct duty splits (R4, R5)
    phase = "R4 R5 fixed";
    set_leg(0, 8, 8); set_leg(1, 0, 0); set_leg(2, -4, 10);
    run(8 * PK + 3);
    // references changed mid-ramp must be ignored (R6)
    phase = "R6 mid-ramp changes";
    for (int k = 0; k < 8 * PK; k++) begin
      @(negedge clk);
      if (k % 3 == 1) begin
        set_leg(0, (k % 21) - 10, (k % 13) - 2);
        set_leg(1, 12 - (k % 17), (k % 9));
        set_leg(2, (k % 7) + 2, 14 - (k % 11));
      end
    end
    // inverted pair, equal boundary, full span (R7)
    phase = "R7 clamp and fault";
    set_leg(0, -10, 4); set_leg(1, 5, -5); set_leg(2, PK, PK);
    run(8 * PK);
    // out-of-range references saturate before the order check (R8)
    phase = "R8 saturation";
    set_leg(0, 100, -100); set_leg(1, -100, 100); set_leg(2, -100, -100);
    run(8 * PK);
    // fault clears once order is restored (R7)
    phase = "R7 fault clear";
    set_leg(0, 3, 3); set_leg(1, 3, 3); set_leg(2, 3, 3);
    run(6 * PK + 5);
    // reset taken mid-run (R9)
    phase = "reset R9 mid-run";
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    phase = "R3 restart";
    run(4 * PK);
    run(2);
    summary();
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog (%s) actual=timeout expected=finish", phase);
    summary();
    $finish;
  end
endmodule